// File: doc/BRIEF.md
# Run-Time Loop Observer

This block sits beside a host processor that has separate instruction and data buses. It only listens to them and never drives them. While the learning phase is selected, it follows the fetch address stream. A fetch whose address is below the previous fetch address, and no more than a set span below it, counts as a backward jump to a loop start. When the same loop start is hit by backward jumps a qualifying number of times, the loop is taken as recognized.

On recognition the block latches a descriptor for an attached accelerator. The descriptor holds:
- the instruction block bounds;
- the lowest and highest data-read addresses seen since the loop was first suspected;
- the lowest data-write address seen in that time, which is the destination;
- the repetition count, which is the job size;
- the instruction word fetched at the loop start, which is the operation code.

A one-cycle descriptor strobe tells the accelerator to load these fields. Observation then stops.

When the serving phase is selected, every fetch of the learned loop start produces a one-cycle bypass pulse. The host uses this pulse to hand that loop to the accelerator.

Top module: `loop_watch`

## Requirements
- R1: After reset, `desc_valid` and `bypass` are 0, and every descriptor output is 0.
- R2: A fetch is a backward jump only when all of these hold: learning is active, a previous fetch exists, the address is lower than the previous fetch address, and the difference is at most MAX_SPAN (default 64). Forward jumps never count. A drop of MAX_SPAN+1 or more never counts.
- R3: A backward jump to the same start address as the current candidate adds 1 to the repetition count, saturating. A backward jump to any other address starts a new candidate with a count of 1 and restarts the address trackers of R6 and R7.
- R4: The threshold is taken from `thresh_init` while `rst_n` is low. A value of 0 acts as 1. The loop is recognized on the backward jump that brings the count to the threshold. `desc_valid` is 1 for exactly the one cycle after that fetch.
- R5: On recognition the descriptor is set as follows:
  - `blk_start` is the target address.
  - `blk_end` is the address of the fetch just before the target.
  - `job_size` is the repetition count.
  - `job_op` is the `if_word` presented with the recognizing fetch.
- R6: `opnd_lo` and `opnd_hi` are the minimum and maximum `rd_addr` of the data reads seen from the cycle the candidate started through the recognizing cycle, including both of those cycles. If no read was seen, `opnd_lo` is all ones and `opnd_hi` is 0.
- R7: `dest_addr` is the minimum `wr_addr` seen over the same window as R6. If no write was seen, it is all ones.
- R8: After recognition, the descriptor outputs stay constant and `desc_valid` does not rise again until the next reset, whatever the buses carry.
- R9: With `serve_mode`=1 after recognition, a fetch at `blk_start` sets `bypass` to 1 for the following cycle only. Each such fetch gives its own pulse. There is never a bypass in learn mode or before recognition.
- R10: While `serve_mode`=1, no candidate is built and no recognition happens, even for a repeating loop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; the threshold is loaded while it is low |
| thresh_init | input | CW | Repetition threshold value |
| serve_mode | input | 1 | 0 = learn phase, 1 = serve phase |
| if_valid | input | 1 | Instruction fetch strobe |
| if_addr | input | AW | Fetch address |
| if_word | input | OPW | Fetched instruction word |
| rd_valid | input | 1 | Data read strobe |
| rd_addr | input | AW | Data read address |
| wr_valid | input | 1 | Data write strobe |
| wr_addr | input | AW | Data write address |
| desc_valid | output | 1 | One-cycle descriptor strobe to the accelerator |
| blk_start | output | AW | Loop start (backward jump target) |
| blk_end | output | AW | Loop end (backward jump source) |
| opnd_lo | output | AW | Lowest read address in the loop |
| opnd_hi | output | AW | Highest read address in the loop |
| dest_addr | output | AW | Lowest write address in the loop |
| job_size | output | CW | Repetition count at recognition |
| job_op | output | OPW | Instruction word at the loop start |
| bypass | output | 1 | One-cycle pulse on a fetch of the learned start in serve phase |

## Verification
The address trackers can update in the same cycle as the fetch that opens a candidate or the fetch that completes recognition. The bench provokes both cases by driving a data read together with each of those fetches. The read on the recognizing fetch uses an address below every earlier read, so it becomes the expected `opnd_lo`. The read on the candidate-opening fetch becomes the expected bound after a target change has discarded an older read. Each case is judged by comparing the latched descriptor fields, and the cycle of the strobe, against the scoreboard entry.

// File: rtl/loop_watch_pkg.sv
package loop_watch_pkg;
  typedef enum logic {
    LW_OBSERVE = 1'b0,
    LW_HOLD    = 1'b1
  } lw_phase_e;
endpackage

// File: rtl/lw_branch_det.sv
module lw_branch_det #(
  parameter int AW       = 16,
  parameter int CW       = 8,
  parameter int MAX_SPAN = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] thresh_init,
  input  logic          learn_en,
  input  logic          if_valid,
  input  logic [AW-1:0] if_addr,
  output logic          bwd_hit,
  output logic          new_cand,
  output logic          cand_live,
  output logic          reached,
  output logic [AW-1:0] src_addr,
  output logic [CW-1:0] cnt_next
);
  localparam logic [AW-1:0] SPAN_A = AW'(MAX_SPAN);
  localparam logic [CW-1:0] ONE_C  = CW'(1);

  logic [AW-1:0] prev_q, start_q;
  logic          prev_v, cand_v;
  logic [CW-1:0] cnt_q, thr_q, thr_eff;
  logic          same_tgt;

  function automatic logic f_backward(input logic [AW-1:0] prev, input logic [AW-1:0] cur);
    return (cur < prev) && ((prev - cur) <= SPAN_A);
  endfunction

  function automatic logic [CW-1:0] f_sat_inc(input logic [CW-1:0] c);
    return (c == {CW{1'b1}}) ? c : c + ONE_C;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) thr_q <= thresh_init;
  end

  assign thr_eff   = (thr_q == '0) ? ONE_C : thr_q;
  assign bwd_hit   = learn_en && if_valid && prev_v && f_backward(prev_q, if_addr);
  assign same_tgt  = bwd_hit && cand_v && (if_addr == start_q);
  assign new_cand  = bwd_hit && !same_tgt;
  assign cnt_next  = same_tgt ? f_sat_inc(cnt_q) : ONE_C;
  assign reached   = bwd_hit && (cnt_next >= thr_eff);
  assign cand_live = cand_v;
  assign src_addr  = prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      prev_v  <= 1'b0;
      cand_v  <= 1'b0;
      start_q <= '0;
      cnt_q   <= '0;
    end else begin
      if (if_valid) begin
        prev_q <= if_addr;
        prev_v <= 1'b1;
      end
      if (new_cand) begin
        cand_v  <= 1'b1;
        start_q <= if_addr;
      end
      if (bwd_hit) cnt_q <= cnt_next;
    end
  end
endmodule

// File: rtl/lw_extent.sv
module lw_extent #(
  parameter int AW       = 16,
  parameter bit TAKE_MAX = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          clr,
  input  logic          smp_v,
  input  logic [AW-1:0] smp_a,
  output logic [AW-1:0] nxt
);
  logic [AW-1:0] cur_q, init_v, picked;

  generate
    if (TAKE_MAX) begin : g_max
      function automatic logic [AW-1:0] f_keep(input logic [AW-1:0] a, input logic [AW-1:0] b);
        return (b > a) ? b : a;
      endfunction
      assign init_v = {AW{1'b0}};
      assign picked = f_keep(cur_q, smp_a);
    end else begin : g_min
      function automatic logic [AW-1:0] f_keep(input logic [AW-1:0] a, input logic [AW-1:0] b);
        return (b < a) ? b : a;
      endfunction
      assign init_v = {AW{1'b1}};
      assign picked = f_keep(cur_q, smp_a);
    end
  endgenerate

  always_comb begin
    if (clr) nxt = smp_v ? smp_a : init_v;
    else     nxt = smp_v ? picked : cur_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cur_q <= {AW{1'b0}};
    else if (en) cur_q <= nxt;
  end
endmodule

// File: rtl/lw_capture.sv
module lw_capture
  import loop_watch_pkg::*;
#(
  parameter int AW  = 16,
  parameter int CW  = 8,
  parameter int OPW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           serve_mode,
  input  logic           if_valid,
  input  logic [AW-1:0]  if_addr,
  input  logic [OPW-1:0] if_word,
  input  logic           reached,
  input  logic [AW-1:0]  src_addr,
  input  logic [CW-1:0]  cnt_next,
  input  logic [AW-1:0]  lo_nxt,
  input  logic [AW-1:0]  hi_nxt,
  input  logic [AW-1:0]  dst_nxt,
  output logic           learned,
  output logic           desc_valid,
  output logic           bypass,
  output logic [AW-1:0]  blk_start,
  output logic [AW-1:0]  blk_end,
  output logic [AW-1:0]  opnd_lo,
  output logic [AW-1:0]  opnd_hi,
  output logic [AW-1:0]  dest_addr,
  output logic [CW-1:0]  job_size,
  output logic [OPW-1:0] job_op
);
  lw_phase_e phase_q;
  logic      start_hit;

  assign learned   = (phase_q == LW_HOLD);
  assign start_hit = serve_mode && learned && if_valid && (if_addr == blk_start);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q    <= LW_OBSERVE;
      desc_valid <= 1'b0;
      bypass     <= 1'b0;
      blk_start  <= '0;
      blk_end    <= '0;
      opnd_lo    <= '0;
      opnd_hi    <= '0;
      dest_addr  <= '0;
      job_size   <= '0;
      job_op     <= '0;
    end else begin
      desc_valid <= reached;
      bypass     <= start_hit;
      if (reached) begin
        phase_q   <= LW_HOLD;
        blk_start <= if_addr;
        blk_end   <= src_addr;
        opnd_lo   <= lo_nxt;
        opnd_hi   <= hi_nxt;
        dest_addr <= dst_nxt;
        job_size  <= cnt_next;
        job_op    <= if_word;
      end
    end
  end
endmodule

// File: rtl/loop_watch.sv
module loop_watch #(
  parameter int AW       = 16,
  parameter int CW       = 8,
  parameter int OPW      = 8,
  parameter int MAX_SPAN = 64
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [CW-1:0]  thresh_init,
  input  logic           serve_mode,
  input  logic           if_valid,
  input  logic [AW-1:0]  if_addr,
  input  logic [OPW-1:0] if_word,
  input  logic           rd_valid,
  input  logic [AW-1:0]  rd_addr,
  input  logic           wr_valid,
  input  logic [AW-1:0]  wr_addr,
  output logic           desc_valid,
  output logic [AW-1:0]  blk_start,
  output logic [AW-1:0]  blk_end,
  output logic [AW-1:0]  opnd_lo,
  output logic [AW-1:0]  opnd_hi,
  output logic [AW-1:0]  dest_addr,
  output logic [CW-1:0]  job_size,
  output logic [OPW-1:0] job_op,
  output logic           bypass
);
  logic          learned_w, learn_en_w;
  logic          bwd_hit_w, new_cand_w, cand_live_w, reached_w, trk_en_w;
  logic [AW-1:0] src_addr_w, lo_nxt_w, hi_nxt_w, dst_nxt_w;
  logic [CW-1:0] cnt_next_w;

  assign learn_en_w = !serve_mode && !learned_w;
  assign trk_en_w   = learn_en_w && (cand_live_w || new_cand_w);

  lw_branch_det #(.AW(AW), .CW(CW), .MAX_SPAN(MAX_SPAN)) br_i (
    .clk(clk), .rst_n(rst_n), .thresh_init(thresh_init), .learn_en(learn_en_w),
    .if_valid(if_valid), .if_addr(if_addr), .bwd_hit(bwd_hit_w), .new_cand(new_cand_w),
    .cand_live(cand_live_w), .reached(reached_w), .src_addr(src_addr_w), .cnt_next(cnt_next_w)
  );

  lw_extent #(.AW(AW), .TAKE_MAX(1'b0)) rd_lo_i (
    .clk(clk), .rst_n(rst_n), .en(trk_en_w), .clr(new_cand_w),
    .smp_v(rd_valid), .smp_a(rd_addr), .nxt(lo_nxt_w)
  );

  lw_extent #(.AW(AW), .TAKE_MAX(1'b1)) rd_hi_i (
    .clk(clk), .rst_n(rst_n), .en(trk_en_w), .clr(new_cand_w),
    .smp_v(rd_valid), .smp_a(rd_addr), .nxt(hi_nxt_w)
  );

  lw_extent #(.AW(AW), .TAKE_MAX(1'b0)) wr_lo_i (
    .clk(clk), .rst_n(rst_n), .en(trk_en_w), .clr(new_cand_w),
    .smp_v(wr_valid), .smp_a(wr_addr), .nxt(dst_nxt_w)
  );

  lw_capture #(.AW(AW), .CW(CW), .OPW(OPW)) cap_i (
    .clk(clk), .rst_n(rst_n), .serve_mode(serve_mode), .if_valid(if_valid),
    .if_addr(if_addr), .if_word(if_word), .reached(reached_w), .src_addr(src_addr_w),
    .cnt_next(cnt_next_w), .lo_nxt(lo_nxt_w), .hi_nxt(hi_nxt_w), .dst_nxt(dst_nxt_w),
    .learned(learned_w), .desc_valid(desc_valid), .bypass(bypass),
    .blk_start(blk_start), .blk_end(blk_end), .opnd_lo(opnd_lo), .opnd_hi(opnd_hi),
    .dest_addr(dest_addr), .job_size(job_size), .job_op(job_op)
  );
endmodule

// File: rtl/lw_checker.sv
module lw_checker #(
  parameter int AW       = 16,
  parameter int MAX_SPAN = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          serve_mode,
  input logic          if_valid,
  input logic [AW-1:0] if_addr,
  input logic          desc_valid,
  input logic          bypass,
  input logic          learned,
  input logic [AW-1:0] blk_start,
  input logic [AW-1:0] blk_end,
  input logic [AW-1:0] opnd_lo,
  input logic [AW-1:0] opnd_hi,
  input logic [AW-1:0] dest_addr
);
  assert_desc_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid |=> !desc_valid);

  assert_bounds_span_R2: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid |-> (blk_start < blk_end) && ((blk_end - blk_start) <= AW'(MAX_SPAN)));

  assert_read_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_valid && (opnd_lo != {AW{1'b1}})) |-> (opnd_lo <= opnd_hi));

  assert_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(learned) |-> learned && !desc_valid && $stable(blk_start) && $stable(blk_end)
                       && $stable(opnd_lo) && $stable(opnd_hi) && $stable(dest_addr));

  assert_bypass_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bypass |-> learned && $past(serve_mode) && $past(if_valid) && ($past(if_addr) == blk_start));

  assert_no_serve_learn_R10: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid |-> !$past(serve_mode));
endmodule

bind loop_watch lw_checker #(.AW(AW), .MAX_SPAN(MAX_SPAN)) chk_i (
  .clk(clk), .rst_n(rst_n), .serve_mode(serve_mode), .if_valid(if_valid), .if_addr(if_addr),
  .desc_valid(desc_valid), .bypass(bypass), .learned(learned_w), .blk_start(blk_start),
  .blk_end(blk_end), .opnd_lo(opnd_lo), .opnd_hi(opnd_hi), .dest_addr(dest_addr)
);

// File: tb/loop_watch_tb_top.sv
module loop_watch_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  thresh_init = '0;
  logic        serve_mode = 1'b0;
  logic        if_valid = 1'b0, rd_valid = 1'b0, wr_valid = 1'b0;
  logic [15:0] if_addr = '0, rd_addr = '0, wr_addr = '0;
  logic [7:0]  if_word = '0;
  logic        desc_valid, bypass;
  logic [15:0] blk_start, blk_end, opnd_lo, opnd_hi, dest_addr;
  logic [7:0]  job_size, job_op;

  always #2.5 clk = ~clk;

  loop_watch dut_i (
    .clk(clk), .rst_n(rst_n), .thresh_init(thresh_init), .serve_mode(serve_mode),
    .if_valid(if_valid), .if_addr(if_addr), .if_word(if_word), .rd_valid(rd_valid),
    .rd_addr(rd_addr), .wr_valid(wr_valid), .wr_addr(wr_addr), .desc_valid(desc_valid),
    .blk_start(blk_start), .blk_end(blk_end), .opnd_lo(opnd_lo), .opnd_hi(opnd_hi),
    .dest_addr(dest_addr), .job_size(job_size), .job_op(job_op), .bypass(bypass)
  );

  typedef struct packed {
    logic [31:0] cyc;
    logic [15:0] bs, be, lo, hi, ds;
    logic [7:0]  js, op;
  } desc_t;

  desc_t       desc_q[$];
  logic [31:0] byp_q[$];
  int          vectors = 0, miscompares = 0, desc_seen = 0, byp_seen = 0;
  logic [31:0] cyc_n = 0;
  bit          done = 0;

  always @(posedge clk) cyc_n <= cyc_n + 1;

  function automatic void chk(input logic [31:0] act, input logic [31:0] exp, input string what);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endfunction

  // Scoreboard monitor
  desc_t e;
  always @(negedge clk) begin
    if (rst_n) begin
      if (desc_valid) begin
        desc_seen++;
        if (desc_q.size() == 0) chk(1, 0, "R8 unexpected desc_valid");
        else begin
          e = desc_q.pop_front();
          chk(cyc_n, e.cyc, "R4 desc_valid cycle");
          chk({16'h0, blk_start}, {16'h0, e.bs}, "R5 blk_start");
          chk({16'h0, blk_end}, {16'h0, e.be}, "R5 blk_end");
          chk({24'h0, job_size}, {24'h0, e.js}, "R5 job_size");
          chk({24'h0, job_op}, {24'h0, e.op}, "R5 job_op");
          chk({16'h0, opnd_lo}, {16'h0, e.lo}, "R6 opnd_lo");
          chk({16'h0, opnd_hi}, {16'h0, e.hi}, "R6 opnd_hi");
          chk({16'h0, dest_addr}, {16'h0, e.ds}, "R7 dest_addr");
        end
      end
      if (bypass) begin
        byp_seen++;
        if (byp_q.size() == 0) chk(1, 0, "R9 unexpected bypass");
        else chk(cyc_n, byp_q.pop_front(), "R9 bypass cycle");
      end
    end
  end

  task automatic drv(input logic iv, input logic [15:0] ia, input logic [7:0] iw,
                     input logic rv, input logic [15:0] ra, input logic wv, input logic [15:0] wa);
    if_valid = iv; if_addr = ia; if_word = iw;
    rd_valid = rv; rd_addr = ra; wr_valid = wv; wr_addr = wa;
    @(negedge clk);
  endtask

  task automatic f(input logic [15:0] a);
    drv(1'b1, a, 8'h00, 1'b0, 16'h0, 1'b0, 16'h0);
  endtask

  task automatic exp_desc(input logic [15:0] bs, be, lo, hi, ds, input logic [7:0] js, op);
    desc_t d;
    d.cyc = cyc_n + 1; d.bs = bs; d.be = be; d.lo = lo; d.hi = hi; d.ds = ds; d.js = js; d.op = op;
    desc_q.push_back(d);
  endtask

  task automatic exp_byp();
    byp_q.push_back(cyc_n + 1);
  endtask

  task automatic do_reset(input logic [7:0] thr);
    rst_n = 1'b0; thresh_init = thr; serve_mode = 1'b0;
    drv(1'b0, 16'h0, 8'h0, 1'b0, 16'h0, 1'b0, 16'h0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({31'h0, desc_valid}, 0, "R1 desc_valid after reset");
    chk({31'h0, bypass}, 0, "R1 bypass after reset");
    chk({16'h0, blk_start}, 0, "R1 blk_start after reset");
    chk({16'h0, opnd_hi}, 0, "R1 opnd_hi after reset");
    chk({24'h0, job_size}, 0, "R1 job_size after reset");
  endtask

  initial begin
    // ---------- Test 1: threshold 3, full descriptor, frozen, serving ----------
    do_reset(8'd3);
    f(16'h00F0);
    for (int it = 0; it < 3; it++) begin
      f(16'h0100); // it>=1: backward jump (R3 count up)
      drv(1'b1, 16'h0101, 8'h00, 1'b1, 16'h2000 + 16'(it), 1'b0, 16'h0);
      drv(1'b1, 16'h0102, 8'h00, 1'b0, 16'h0, 1'b1, 16'h3010 - 16'(it));
      f(16'h0103);
    end
    // recognizing fetch with a same-cycle read below all others (R6)
    exp_desc(16'h0100, 16'h0103, 16'h1FFF, 16'h2002, 16'h300E, 8'd3, 8'hC3);
    drv(1'b1, 16'h0100, 8'hC3, 1'b1, 16'h1FFF, 1'b0, 16'h0);
    // after recognition: traffic ignored (R8), learn-mode fetch of start gives no bypass (R9)
    drv(1'b1, 16'h0101, 8'h00, 1'b1, 16'h0005, 1'b0, 16'h0);
    drv(1'b1, 16'h0102, 8'h00, 1'b0, 16'h0, 1'b1, 16'h0001);
    f(16'h0103);
    f(16'h0100);
    f(16'h0103);
    f(16'h0100);
    chk({16'h0, opnd_lo}, 32'h1FFF, "R8 opnd_lo frozen");
    chk({16'h0, dest_addr}, 32'h300E, "R8 dest_addr frozen");
    chk({16'h0, blk_start}, 32'h0100, "R8 blk_start frozen");
    // serving
    serve_mode = 1'b1;
    f(16'h00F0);
    exp_byp(); f(16'h0100);
    f(16'h0101); f(16'h0102); f(16'h0103);
    exp_byp(); f(16'h0100);
    exp_byp(); f(16'h0100);  // back-to-back fetches of start: one pulse each (R9)
    f(16'h00FF); f(16'h0101);
    drv(1'b0, 16'h0100, 8'h0, 1'b0, 16'h0, 1'b0, 16'h0); // no strobe, no bypass
    f(16'h0000);
    serve_mode = 1'b0;
    chk(desc_seen, 1, "R8 single descriptor in test 1");
    chk(byp_seen, 3, "R9 bypass count in test 1");

    // ---------- Test 2: threshold 0 acts as 1, span boundary ----------
    do_reset(8'd0);
    f(16'h0300); f(16'h0341);
    f(16'h0300);               // drop of 65: not backward (R2)
    f(16'h0200);               // drop of 256: not backward (R2)
    f(16'h0240);               // forward
    exp_desc(16'h0200, 16'h0240, 16'hFFFF, 16'h0000, 16'h5000, 8'd1, 8'h7E);
    drv(1'b1, 16'h0200, 8'h7E, 1'b0, 16'h0, 1'b1, 16'h5000); // drop of 64: recognized (R4)
    f(16'h0240);
    f(16'h0200);               // learn mode after learning: no bypass (R9)
    chk(desc_seen, 2, "R2 window boundary descriptor count");
    chk(byp_seen, 3, "R9 no bypass in learn mode");

    // ---------- Test 3: threshold 2, serve blocks learning, target change ----------
    do_reset(8'd2);
    serve_mode = 1'b1;
    f(16'h0000);               // matches reset blk_start but not learned (R9)
    f(16'h0500); f(16'h0501); f(16'h0500); f(16'h0501); f(16'h0500); f(16'h0501); f(16'h0500);
    serve_mode = 1'b0;
    chk(desc_seen, 2, "R10 no recognition while serving");
    chk(byp_seen, 3, "R9 no bypass before learning");
    f(16'h0400);               // drop of 256 from 0x500: not backward
    f(16'h0401);
    drv(1'b1, 16'h0400, 8'h00, 1'b1, 16'h0010, 1'b0, 16'h0); // candidate A, count 1
    f(16'h0410);
    drv(1'b1, 16'h0405, 8'h00, 1'b1, 16'h0050, 1'b0, 16'h0); // candidate B restarts (R3)
    drv(1'b1, 16'h0406, 8'h00, 1'b1, 16'h0060, 1'b0, 16'h0);
    exp_desc(16'h0405, 16'h0406, 16'h0050, 16'h0060, 16'hFFFF, 8'd2, 8'h3C);
    drv(1'b1, 16'h0405, 8'h3C, 1'b0, 16'h0, 1'b0, 16'h0);
    f(16'h0406);
    drv(1'b0, 16'h0, 8'h0, 1'b0, 16'h0, 1'b0, 16'h0);
    chk(desc_seen, 3, "R3 descriptor after target change");
    chk(desc_q.size(), 0, "R4 all expected descriptors seen");
    chk(byp_q.size(), 0, "R9 all expected bypasses seen");

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      miscompares++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule